// File: doc/BRIEF.md
# Dual-Gain Automatic Gain Control Loop

This block closes a digital gain-control loop around a complex baseband sample stream. Each accepted I/Q pair is turned into an instantaneous power (I squared plus Q squared). A selectable number of these powers, from one to four, is averaged. The average is converted into a logarithmic level whose unit is 1/64 of a 6.02 dB step, which is the same unit the programmed target level uses.

The loop error is the target minus the measured level. A first-order recursive filter, with an 8-bit fractional pole, integrates this error into a 16-bit signed gain word. The filter weights the error with one of two 8-bit fractional gains: a fine gain while the error magnitude stays under a threshold, and a coarse gain at or above it. On each filter update the block presents the new gain word and the measured level, and pulses a strobe for one cycle.

The pole and both loop gains are working copies. They are captured from their input ports only when the loop is initialised. Applying the gain word to the signal path lies outside this block.

Top module: `agc_loop`

## Requirements
- R1: When `avg_sel` is 0, 1, 2 or 3, the block averages 1, 2, 3 or 4 accepted powers, where each power is I*I+Q*Q. The average is floor(sum/N). Exactly one loop update follows each group of N.
- R2: `rssi_out` holds the level of the averaged power p. The level is 0 when p is 0. Otherwise it is 32*e + T[m], where e is the bit position of the leading one of p and m is the four bits just below that leading one, with zeros filling in below bit 0. T[m] = round(32*log2(1+m/16)).
- R3: The error is the signed value `req_level` minus the level. When |error| is less than `err_thr`, the update uses the first loop gain; otherwise it uses the second.
- R4: The gain word updates as y = sat16(floor(P*y/256) + K*error), where P and K are raw 8-bit codes. sat16 clamps the result to the range -32768 to 32767.
- R5: `rssi_valid` is high for exactly one cycle per loop update. That cycle is the fourth rising edge counted from the edge that accepts the last sample of the group, and `gain_out` and `rssi_out` are already new in that cycle.
- R6: Changes on `pole_in`, `k1_in` and `k2_in` have no effect on later updates until `agc_init` is pulsed. At that pulse the block takes the values present on these ports.
- R7: An `agc_init` pulse clears the partly filled average, the sample count, any results still in the pipeline and the gain word. The next group is counted from the first sample accepted after the pulse.
- R8: After reset, `gain_out`, `rssi_out` and `rssi_valid` are all 0.
- R9: A sample presented while `iq_valid` is low is ignored. It produces no strobe and does not enter any average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| agc_init | input | 1 | Loop initialisation pulse |
| iq_valid | input | 1 | Qualifies the sample on i_in/q_in |
| i_in | input | DATA_W | In-phase sample, signed |
| q_in | input | DATA_W | Quadrature sample, signed |
| avg_sel | input | 2 | Averaging length code (N = code+1) |
| pole_in | input | 8 | Filter pole, fraction of 256 |
| k1_in | input | 8 | Fine loop gain, fraction of 256 |
| k2_in | input | 8 | Coarse loop gain, fraction of 256 |
| req_level | input | 8 | Target level, 1/64 of 6.02 dB units |
| err_thr | input | LVL_W | Error magnitude threshold for gain choice |
| gain_out | output | 16 | Loop filter state, signed |
| rssi_out | output | LVL_W | Measured log level |
| rssi_valid | output | 1 | One-cycle update strobe |

## Verification
Every result leaves through four register stages: power, average, log level, then filter. The gain word, the level and the strobe for a group are therefore due on the fourth rising edge after the edge that takes the group's last sample. The driver stamps each expected item with that cycle number, computed from a free-running edge counter. The monitor samples on falling edges and compares the stamp with the current count, so an early or late result fails even when its value is correct. The target and the threshold are read at the filter stage and the averaging length at the averaging stage, so the bench changes them only after the pipeline has drained.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int COEF_W = 8;
    localparam int GAIN_W = 16;
    localparam int MANT_W = 4;
    localparam int FRAC_W = 5;   // level steps per octave of power = 2**FRAC_W

    typedef logic [COEF_W-1:0] coef_t;

    typedef struct packed {
        coef_t pole;
        coef_t k_fine;
        coef_t k_coarse;
    } loop_cfg_t;

    // round(32*log2(1+m/16))
    function automatic logic [FRAC_W-1:0] mant_log(input logic [MANT_W-1:0] m);
        logic [FRAC_W-1:0] r;
        case (m)
            4'd0:  r = 5'd0;
            4'd1:  r = 5'd3;
            4'd2:  r = 5'd5;
            4'd3:  r = 5'd8;
            4'd4:  r = 5'd10;
            4'd5:  r = 5'd13;
            4'd6:  r = 5'd15;
            4'd7:  r = 5'd17;
            4'd8:  r = 5'd19;
            4'd9:  r = 5'd21;
            4'd10: r = 5'd22;
            4'd11: r = 5'd24;
            4'd12: r = 5'd26;
            4'd13: r = 5'd27;
            4'd14: r = 5'd29;
            default: r = 5'd31;
        endcase
        return r;
    endfunction

    function automatic logic signed [GAIN_W-1:0] sat_gain(input logic signed [31:0] v);
        logic signed [GAIN_W-1:0] r;
        if (v > 32'sd32767)
            r = 16'sh7fff;
        else if (v < -32'sd32768)
            r = 16'sh8000;
        else
            r = v[GAIN_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/agc_power.sv
module agc_power #(
    parameter int DATA_W = 12,
    localparam int POW_W = 2*DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] i_s,
    input  logic signed [DATA_W-1:0] q_s,
    output logic                     pow_valid,
    output logic [POW_W-1:0]         pow
);
    logic signed [POW_W-1:0] ii, qq;

    always_comb begin
        ii = i_s * i_s;
        qq = q_s * q_s;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pow_valid <= 1'b0;
            pow       <= '0;
        end else begin
            pow_valid <= in_valid;
            if (in_valid)
                pow <= $unsigned(ii) + $unsigned(qq);
        end
    end

    a_r9_idle_no_power: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !pow_valid);

endmodule

// File: rtl/agc_avg.sv
module agc_avg #(
    parameter int POW_W = 24,
    localparam int ACC_W = POW_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [POW_W-1:0] pow,
    input  logic [1:0]       n_code,
    output logic             avg_valid,
    output logic [POW_W-1:0] avg
);
    logic [ACC_W-1:0] acc, total, quot;
    logic [1:0]       cnt;
    logic             last;

    always_comb begin
        total = acc + ACC_W'(pow);
        last  = (cnt >= n_code);
        case (n_code)
            2'd0:    quot = total;
            2'd1:    quot = total >> 1;
            2'd2:    quot = total / ACC_W'(3);
            default: quot = total >> 2;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc       <= '0;
            cnt       <= '0;
            avg_valid <= 1'b0;
            avg       <= '0;
        end else begin
            avg_valid <= 1'b0;
            if (in_valid) begin
                if (last) begin
                    acc       <= '0;
                    cnt       <= '0;
                    avg       <= POW_W'(quot);
                    avg_valid <= 1'b1;
                end else begin
                    acc <= total;
                    cnt <= cnt + 2'd1;
                end
            end
        end
    end

    a_r1_avg_needs_input: assert property (@(posedge clk) disable iff (rst)
        avg_valid |-> $past(in_valid));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == 2'd0 && !avg_valid));

endmodule

// File: rtl/agc_log.sv
module agc_log
    import agc_pkg::*;
#(
    parameter int POW_W = 24,
    parameter int LVL_W = 10,
    localparam int EXP_W = $clog2(POW_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [POW_W-1:0] avg,
    output logic             lvl_valid,
    output logic [LVL_W-1:0] lvl
);
    logic [EXP_W-1:0]  e;
    logic [MANT_W-1:0] m;
    logic [LVL_W-1:0]  lvl_c;

    always_comb begin
        e = '0;
        for (int b = 0; b < POW_W; b++)
            if (avg[b])
                e = EXP_W'(b);
        m = MANT_W'({avg, {MANT_W{1'b0}}} >> e);
        if (avg == '0)
            lvl_c = '0;
        else
            lvl_c = LVL_W'({e, {FRAC_W{1'b0}}}) + LVL_W'(mant_log(m));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lvl_valid <= 1'b0;
            lvl       <= '0;
        end else begin
            lvl_valid <= in_valid;
            if (in_valid)
                lvl <= lvl_c;
        end
    end

    a_r2_zero_power_zero_level: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && avg == '0) |=> (lvl_valid && lvl == '0));

endmodule

// File: rtl/agc_filter.sv
module agc_filter
    import agc_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init,
    input  loop_cfg_t                cfg_in,
    input  logic                     in_valid,
    input  logic [LVL_W-1:0]         lvl,
    input  coef_t                    req,
    input  logic [LVL_W-1:0]         thr,
    output logic signed [GAIN_W-1:0] y,
    output logic [LVL_W-1:0]         rssi,
    output logic                     upd
);
    loop_cfg_t          cfg_q;
    coef_t              k_sel;
    logic signed [31:0] err_s, mag, prod_p, prod_k, y_sum;

    always_comb begin
        err_s  = $signed(32'(req)) - $signed(32'(lvl));
        mag    = (err_s < 0) ? -err_s : err_s;
        k_sel  = (mag < $signed(32'(thr))) ? cfg_q.k_fine : cfg_q.k_coarse;
        prod_p = $signed(32'(cfg_q.pole)) * 32'(y);
        prod_k = $signed(32'(k_sel)) * err_s;
        y_sum  = (prod_p >>> 8) + prod_k;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            y     <= '0;
            rssi  <= '0;
            upd   <= 1'b0;
        end else if (init) begin
            cfg_q <= cfg_in;
            y     <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= in_valid;
            if (in_valid) begin
                y    <= sat_gain(y_sum);
                rssi <= lvl;
            end
        end
    end

    a_r6_cfg_only_on_init: assert property (@(posedge clk) disable iff (rst)
        !init |=> $stable(cfg_q));

    a_r4_state_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !init) |=> $stable(y));

    a_r7_init_clears_state: assert property (@(posedge clk) disable iff (rst)
        init |=> (y == '0 && !upd));

endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int POW_W = 2*DATA_W,
    localparam int LVL_W = $clog2(POW_W << FRAC_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     agc_init,
    input  logic                     iq_valid,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    input  logic [1:0]               avg_sel,
    input  logic [COEF_W-1:0]        pole_in,
    input  logic [COEF_W-1:0]        k1_in,
    input  logic [COEF_W-1:0]        k2_in,
    input  logic [COEF_W-1:0]        req_level,
    input  logic [LVL_W-1:0]         err_thr,
    output logic signed [GAIN_W-1:0] gain_out,
    output logic [LVL_W-1:0]         rssi_out,
    output logic                     rssi_valid
);
    logic             pow_valid, avg_valid, lvl_valid;
    logic [POW_W-1:0] pow, avg;
    logic [LVL_W-1:0] lvl;
    loop_cfg_t        cfg_in;

    assign cfg_in = '{pole: pole_in, k_fine: k1_in, k_coarse: k2_in};

    agc_power #(.DATA_W(DATA_W)) u_power (
        .clk(clk), .rst(rst), .flush(agc_init),
        .in_valid(iq_valid), .i_s(i_in), .q_s(q_in),
        .pow_valid(pow_valid), .pow(pow)
    );

    agc_avg #(.POW_W(POW_W)) u_avg (
        .clk(clk), .rst(rst), .flush(agc_init),
        .in_valid(pow_valid), .pow(pow), .n_code(avg_sel),
        .avg_valid(avg_valid), .avg(avg)
    );

    agc_log #(.POW_W(POW_W), .LVL_W(LVL_W)) u_log (
        .clk(clk), .rst(rst), .flush(agc_init),
        .in_valid(avg_valid), .avg(avg),
        .lvl_valid(lvl_valid), .lvl(lvl)
    );

    agc_filter #(.LVL_W(LVL_W)) u_filter (
        .clk(clk), .rst(rst), .init(agc_init), .cfg_in(cfg_in),
        .in_valid(lvl_valid), .lvl(lvl), .req(req_level), .thr(err_thr),
        .y(gain_out), .rssi(rssi_out), .upd(rssi_valid)
    );

    a_r5_strobe_follows_level: assert property (@(posedge clk) disable iff (rst)
        rssi_valid |-> $past(lvl_valid));

endmodule

// File: tb/agc_loop_test.sv
module agc_loop_test;
    localparam int DATA_W = 12;
    localparam int LVL_W  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic agc_init = 1'b0;
    logic iq_valid = 1'b0;
    logic signed [DATA_W-1:0] i_in = '0, q_in = '0;
    logic [1:0] avg_sel = '0;
    logic [7:0] pole_in = '0, k1_in = '0, k2_in = '0, req_level = '0;
    logic [LVL_W-1:0] err_thr = '0;
    logic signed [15:0] gain_out;
    logic [LVL_W-1:0] rssi_out;
    logic rssi_valid;

    agc_loop #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .agc_init(agc_init), .iq_valid(iq_valid),
        .i_in(i_in), .q_in(q_in), .avg_sel(avg_sel), .pole_in(pole_in),
        .k1_in(k1_in), .k2_in(k2_in), .req_level(req_level), .err_thr(err_thr),
        .gain_out(gain_out), .rssi_out(rssi_out), .rssi_valid(rssi_valid)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int    lvl;
        int    gain;
        int    due;
        string tag;
    } item_t;

    item_t sb[$];
    int cyc = 0, checks = 0, errors = 0, pulses = 0;
    int m_p = 0, m_k1 = 0, m_k2 = 0, m_y = 0;
    int acc_sum = 0, acc_cnt = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    function automatic int level_of(int p);
        int e, m, t;
        if (p == 0) return 0;
        e = 0;
        for (int b = 0; b < 31; b++) if (p[b]) e = b;
        m = ((p << 4) >> e) & 15;
        t = $rtoi(32.0 * $ln(1.0 + m / 16.0) / $ln(2.0) + 0.5);
        return 32 * e + t;
    endfunction

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic do_init(int p, int k1, int k2);
        @(negedge clk);
        iq_valid = 1'b0;
        pole_in = 8'(p); k1_in = 8'(k1); k2_in = 8'(k2);
        agc_init = 1'b1;
        m_p = p; m_k1 = k1; m_k2 = k2; m_y = 0;
        acc_sum = 0; acc_cnt = 0;
        @(negedge clk);
        agc_init = 1'b0;
    endtask

    task automatic send(int iv, int qv, string tag);
        int n, avg, lvl, err, mag, k;
        item_t it;
        @(negedge clk);
        iq_valid = 1'b1;
        i_in = DATA_W'(iv);
        q_in = DATA_W'(qv);
        acc_sum += iv * iv + qv * qv;
        acc_cnt++;
        n = int'(avg_sel) + 1;
        if (acc_cnt == n) begin
            avg = acc_sum / n;
            lvl = level_of(avg);
            err = int'(req_level) - lvl;
            mag = (err < 0) ? -err : err;
            k = (mag < int'(err_thr)) ? m_k1 : m_k2;
            m_y = sat16(((m_p * m_y) >>> 8) + k * err);
            it.lvl = lvl; it.gain = m_y; it.due = cyc + 4; it.tag = tag;
            sb.push_back(it);
            acc_sum = 0; acc_cnt = 0;
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        iq_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && rssi_valid) begin
            pulses++;
            if (sb.size() == 0) begin
                chk(1'b0, "R5 strobe without pending group", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(int'(rssi_out) == it.lvl, {it.tag, " level (R2)"}, int'(rssi_out), it.lvl);
                chk(int'(gain_out) == it.gain, {it.tag, " gain (R4)"}, int'(gain_out), it.gain);
                chk(cyc == it.due, {it.tag, " strobe cycle (R5)"}, cyc, it.due);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk(gain_out == 0, "R8 gain after reset", int'(gain_out), 0);
        chk(rssi_out == 0, "R8 rssi after reset", int'(rssi_out), 0);
        chk(rssi_valid == 0, "R8 strobe after reset", int'(rssi_valid), 0);

        // R2: single-sample groups, varied magnitudes
        avg_sel = 2'd0; req_level = 8'd200; err_thr = 10'd40;
        do_init(128, 64, 16);
        send(100, 0, "R2");
        send(0, 300, "R2");
        send(1000, -1000, "R2");
        send(5, 7, "R2");
        send(0, 0, "R2 zero power");
        send(-2048, 3, "R2");
        idle(8);

        // R1: averaging lengths 2, 3, 4
        avg_sel = 2'd1;
        send(300, 20, "R1 n2"); send(-50, 700, "R1 n2");
        send(1, 1, "R1 n2");    send(0, 2, "R1 n2");
        idle(8);
        avg_sel = 2'd2;
        send(10, 10, "R1 n3"); send(400, -3, "R1 n3"); send(77, 0, "R1 n3");
        idle(8);
        avg_sel = 2'd3;
        send(1, 0, "R1 n4"); send(2, 0, "R1 n4"); send(3, 0, "R1 n4");
        idle(3);
        send(900, 900, "R1 n4");
        idle(8);

        // R3: threshold chooses fine or coarse gain
        avg_sel = 2'd0; req_level = 8'd200; err_thr = 10'd300;
        do_init(200, 100, 10);
        send(0, 0, "R3 fine");
        send(1500, 1500, "R3 coarse");
        send(14, 0, "R3 fine");
        idle(8);
        err_thr = 10'd200;
        send(0, 0, "R3 at threshold");
        idle(8);

        // R6: port changes without init take no effect
        pole_in = 8'd3; k1_in = 8'd250; k2_in = 8'd250;
        send(60, 60, "R6 stale cfg");
        send(0, 0, "R6 stale cfg");
        idle(8);
        do_init(230, 40, 5);
        send(60, 60, "R6 new cfg");
        send(0, 0, "R6 new cfg");
        idle(8);

        // R9: samples with valid low are ignored
        p0 = pulses;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            iq_valid = 1'b0;
            i_in = DATA_W'(j * 97 - 300);
            q_in = DATA_W'(j * 13);
        end
        idle(6);
        chk(pulses == p0, "R9 no strobe for invalid samples", pulses, p0);
        avg_sel = 2'd1;
        send(250, 0, "R9 average unaffected");
        send(0, 250, "R9 average unaffected");
        idle(8);

        // R7: init mid-group restarts counting and clears state
        avg_sel = 2'd2;
        send(2000, 2000, "R7");
        idle(2);
        do_init(100, 30, 30);
        chk(gain_out == 0, "R7 gain cleared", int'(gain_out), 0);
        send(5, 5, "R7 fresh group"); send(6, 6, "R7 fresh group"); send(7, 7, "R7 fresh group");
        idle(8);

        // R4: saturation both ways
        avg_sel = 2'd0; req_level = 8'd255; err_thr = 10'd0;
        do_init(255, 255, 255);
        send(0, 0, "R4 positive clamp");
        send(0, 0, "R4 positive clamp");
        send(-2048, -2048, "R4 negative clamp");
        send(-2048, -2048, "R4 negative clamp");
        send(-2048, -2048, "R4 negative clamp");
        idle(10);

        chk(sb.size() == 0, "R5 all groups produced a strobe", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule